// File: doc/BRIEF.md
# Bidirectional GPIO Port with Peripheral Pin Takeover

This block is an eight-pin general-purpose I/O port for a microcontroller. Software reaches it over a small register bus with combinational reads. For each pin there is an output value register and a direction register. Reading the live-level address returns what the pad shows after a two-flop synchroniser. Reading the output address returns the stored output value. Writing either of those two addresses updates the stored output value.

The low four pins double as external-interrupt sources. Each has a sticky edge flag whose polarity can be selected, and software clears a flag by writing a one to it. Each pin exposes a weak pull-up request, which is asserted only when the pin is an input and the global active-low pull-up control allows it. When a configuration strap is low and the operating mode is any external-memory mode, pin 3 is handed to a capture/compare/PWM unit. In that case its driver enable and drive value come from the unit, and its synchronised level feeds the unit's capture input instead of the pin-3 interrupt.

Top module: `gpio_port_ovr`

## Requirements
- R1: A write to address 0 (live level) or address 1 (output value) loads the output value register. Reading address 1 returns that register. `pad_do[i]` follows it on every pin that is not taken over. Its reset value is 0x00.
- R2: Address 2 is the direction register, and it reads back what was written. A bit of 1 makes the pin an input (`pad_oe[i]`=0). A bit of 0 makes it an output. Its reset value is 0xFF.
- R3: A read of address 0 returns the pad level two clock edges after the pad changes, through two flops.
- R4: `pad_pu[i]` equals direction bit i AND NOT the pull-up-off bit.
- R5: Address 3 is the control register. Bit 0 is pull-up-off, which is active high and so disables pull-ups. Bits 7:4 select the edge for interrupt sources 3..0 (1 = rising, 0 = falling). Bits 3:1 read as 0. Its reset value is 0xF1.
- R6: The takeover is active when `mux_cfg`=0 and `op_mode`≠0. While it is active, `pad_oe[3]`=`per_oe` and `pad_do[3]`=`per_out`. Otherwise pin 3 behaves like the other pins.
- R7: While the takeover is active, `per_cap` equals the synchronised pin-3 level and interrupt source 3 cannot set. Otherwise `per_cap` is 0.
- R8: Flag i (pins 0..3) sets one edge after the synchronised level of pin i shows the selected edge. It then stays set. Flags read on bits 3:0 of address 4 and on `irq_flags`.
- R9: A write to address 4 clears each flag whose data bit is 1. If a new edge arrives in the same cycle, the set wins.
- R10: Addresses 5 to 7 read as 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational) |
| pad_di | input | 8 | Pad input levels |
| pad_do | output | 8 | Pad drive values |
| pad_oe | output | 8 | Pad driver enables |
| pad_pu | output | 8 | Weak pull-up requests |
| mux_cfg | input | 1 | Pin-3 takeover strap, 0 allows takeover |
| op_mode | input | 2 | Operating mode, 0 = internal-only |
| per_out | input | 1 | Peripheral drive value for pin 3 |
| per_oe | input | 1 | Peripheral driver enable for pin 3 |
| per_cap | output | 1 | Synchronised pin 3 to peripheral capture |
| irq_flags | output | 4 | Sticky interrupt flags |

## Verification
The bench targets these corner cases:
- A clear and an edge arriving on the same flag in the same cycle. A design that lets the clear win loses an interrupt.
- Edges produced by the pull-ups themselves when they are switched on. Getting the latency wrong shifts the flag by a cycle.
- Toggling `mux_cfg` and `op_mode` while pin 3 is busy. A wrong takeover condition drives the pin from the wrong source, leaks pull-ups onto output pins, or lets pin-3 edges raise an interrupt while the peripheral owns the pin.
- Stray writes to unmapped addresses, which would corrupt a register if decoding were loose.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

  typedef enum logic [2:0] {
    GA_PIN = 3'd0,
    GA_LAT = 3'd1,
    GA_DIR = 3'd2,
    GA_CTL = 3'd3,
    GA_FLG = 3'd4
  } gpio_addr_e;

  // Edge detector on a synchronised level and its one-cycle-old copy.
  function automatic logic edge_hit(input logic rise_sel, input logic cur, input logic prev);
    return rise_sel ? (cur & ~prev) : (~cur & prev);
  endfunction

  // Weak pull-up request: pin is an input and pull-ups are not switched off.
  function automatic logic pull_on(input logic dir_in, input logic pu_off);
    return dir_in & ~pu_off;
  endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] raw,
  output logic [W-1:0] level,
  output logic [W-1:0] level_d
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta    <= '0;
      level   <= '0;
      level_d <= '0;
    end else begin
      meta    <= raw;
      level   <= meta;
      level_d <= level;
    end
  end
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_pkg::*;
#(
  parameter int W    = 8,
  parameter int NIRQ = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr,
  input  logic [2:0]      addr,
  input  logic [W-1:0]    wdata,
  output logic [W-1:0]    lat,
  output logic [W-1:0]    dir,
  output logic            pu_off,
  output logic [NIRQ-1:0] rise_sel
);
  gpio_addr_e a;
  logic wr_lat, wr_dir, wr_ctl;

  assign a      = gpio_addr_e'(addr);
  assign wr_lat = wr && (a == GA_PIN || a == GA_LAT);
  assign wr_dir = wr && (a == GA_DIR);
  assign wr_ctl = wr && (a == GA_CTL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat      <= '0;
      dir      <= '1;
      pu_off   <= 1'b1;
      rise_sel <= '1;
    end else begin
      if (wr_lat) lat <= wdata;
      if (wr_dir) dir <= wdata;
      if (wr_ctl) begin
        pu_off   <= wdata[0];
        rise_sel <= wdata[W-1 -: NIRQ];
      end
    end
  end
endmodule

// File: rtl/gpio_irq.sv
module gpio_irq
  import gpio_pkg::*;
#(
  parameter int NIRQ     = 4,
  parameter int GATE_IDX = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NIRQ-1:0] cur,
  input  logic [NIRQ-1:0] prev,
  input  logic [NIRQ-1:0] rise_sel,
  input  logic            gate_off,
  input  logic [NIRQ-1:0] clr,
  output logic [NIRQ-1:0] ev,
  output logic [NIRQ-1:0] flags
);
  for (genvar i = 0; i < NIRQ; i++) begin : g_src
    if (i == GATE_IDX) begin : g_gated
      assign ev[i] = edge_hit(rise_sel[i], cur[i], prev[i]) & ~gate_off;
    end else begin : g_plain
      assign ev[i] = edge_hit(rise_sel[i], cur[i], prev[i]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= '0;
    else        flags <= ev | (flags & ~clr);
  end
endmodule

// File: rtl/gpio_port_ovr.sv
module gpio_port_ovr
  import gpio_pkg::*;
#(
  parameter int W       = 8,
  parameter int NIRQ    = 4,
  parameter int OVR_PIN = 3,
  parameter int MODE_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [2:0]        bus_addr,
  input  logic [W-1:0]      bus_wdata,
  output logic [W-1:0]      bus_rdata,
  input  logic [W-1:0]      pad_di,
  output logic [W-1:0]      pad_do,
  output logic [W-1:0]      pad_oe,
  output logic [W-1:0]      pad_pu,
  input  logic              mux_cfg,
  input  logic [MODE_W-1:0] op_mode,
  input  logic              per_out,
  input  logic              per_oe,
  output logic              per_cap,
  output logic [NIRQ-1:0]   irq_flags
);
  localparam int ESEL_LO = W - NIRQ;

  logic [W-1:0]    lat, dir, lvl, lvl_d;
  logic            pu_off, ovr_active;
  logic [NIRQ-1:0] rise_sel, clr_vec, edge_ev;
  gpio_addr_e      a;

  assign a          = gpio_addr_e'(bus_addr);
  assign ovr_active = ~mux_cfg & (op_mode != '0);
  assign clr_vec    = (bus_wr && a == GA_FLG) ? bus_wdata[NIRQ-1:0] : '0;
  assign per_cap    = ovr_active & lvl[OVR_PIN];

  gpio_regs #(.W(W), .NIRQ(NIRQ)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .lat(lat), .dir(dir), .pu_off(pu_off), .rise_sel(rise_sel)
  );

  gpio_sync #(.W(W)) u_sync (
    .clk(clk), .rst_n(rst_n), .raw(pad_di), .level(lvl), .level_d(lvl_d)
  );

  gpio_irq #(.NIRQ(NIRQ), .GATE_IDX(OVR_PIN)) u_irq (
    .clk(clk), .rst_n(rst_n), .cur(lvl[NIRQ-1:0]), .prev(lvl_d[NIRQ-1:0]),
    .rise_sel(rise_sel), .gate_off(ovr_active), .clr(clr_vec),
    .ev(edge_ev), .flags(irq_flags)
  );

  for (genvar i = 0; i < W; i++) begin : g_pin
    assign pad_pu[i] = pull_on(dir[i], pu_off);
    if (i == OVR_PIN) begin : g_shared
      assign pad_oe[i] = ovr_active ? per_oe  : ~dir[i];
      assign pad_do[i] = ovr_active ? per_out : lat[i];
    end else begin : g_own
      assign pad_oe[i] = ~dir[i];
      assign pad_do[i] = lat[i];
    end
  end

  always_comb begin
    bus_rdata = '0;
    unique case (a)
      GA_PIN: bus_rdata = lvl;
      GA_LAT: bus_rdata = lat;
      GA_DIR: bus_rdata = dir;
      GA_CTL: begin
        bus_rdata[0]              = pu_off;
        bus_rdata[W-1:ESEL_LO]    = rise_sel;
      end
      GA_FLG: bus_rdata[NIRQ-1:0] = irq_flags;
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/gpio_port_ovr_chk.sv
module gpio_port_ovr_chk #(
  parameter int W       = 8,
  parameter int NIRQ    = 4,
  parameter int OVR_PIN = 3,
  parameter int MODE_W  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic [2:0]        bus_addr,
  input logic [W-1:0]      bus_wdata,
  input logic [W-1:0]      pad_do,
  input logic [W-1:0]      pad_oe,
  input logic [W-1:0]      pad_pu,
  input logic              mux_cfg,
  input logic [MODE_W-1:0] op_mode,
  input logic              per_out,
  input logic              per_oe,
  input logic              per_cap,
  input logic [NIRQ-1:0]   irq_flags,
  input logic [NIRQ-1:0]   edge_ev,
  input logic [NIRQ-1:0]   clr_vec
);
  localparam logic [W-1:0] NOT_OVR = ~(W'(1) << OVR_PIN);
  logic takeover;
  assign takeover = !mux_cfg && (op_mode != '0);

  p_lat_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && (bus_addr == 3'd0 || bus_addr == 3'd1))
      |=> (((pad_do ^ $past(bus_wdata)) & NOT_OVR) == '0));

  p_dir_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 3'd2) |=> (((pad_oe ^ ~$past(bus_wdata)) & NOT_OVR) == '0));

  p_pull_input_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_pu & pad_oe & NOT_OVR) == '0);

  p_takeover_drive_r6: assert property (@(posedge clk) disable iff (!rst_n)
    takeover |-> (pad_oe[OVR_PIN] == per_oe && pad_do[OVR_PIN] == per_out));

  p_cap_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !takeover |-> !per_cap);

  p_edge_sets_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_ev != '0) |=> (($past(edge_ev) & ~irq_flags) == '0));

  p_flag_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_flags != '0) |=> ((($past(irq_flags) & ~$past(clr_vec)) & ~irq_flags) == '0));

  p_unmapped_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr > 3'd4)
      |=> ($stable(pad_do & NOT_OVR) && $stable(pad_oe & NOT_OVR) && $stable(pad_pu)));
endmodule

bind gpio_port_ovr gpio_port_ovr_chk #(.W(W), .NIRQ(NIRQ), .OVR_PIN(OVR_PIN), .MODE_W(MODE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .pad_do(pad_do), .pad_oe(pad_oe), .pad_pu(pad_pu), .mux_cfg(mux_cfg), .op_mode(op_mode),
  .per_out(per_out), .per_oe(per_oe), .per_cap(per_cap), .irq_flags(irq_flags),
  .edge_ev(edge_ev), .clr_vec(clr_vec)
);

// File: tb/gpio_port_ovr_tb_top.sv
`timescale 1ns/1ps
module gpio_port_ovr_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata, pad_di, pad_do, pad_oe, pad_pu;
  logic       mux_cfg = 1'b1;
  logic [1:0] op_mode = '0;
  logic       per_out = 1'b0, per_oe = 1'b0;
  logic       per_cap;
  logic [3:0] irq_flags;
  logic [7:0] ext_en = '0, ext_val = '0;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0, cmp_on = 1'b0;

  always #2 clk = ~clk;

  gpio_port_ovr dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .pad_di(pad_di), .pad_do(pad_do), .pad_oe(pad_oe), .pad_pu(pad_pu),
    .mux_cfg(mux_cfg), .op_mode(op_mode), .per_out(per_out), .per_oe(per_oe),
    .per_cap(per_cap), .irq_flags(irq_flags)
  );

  // Pad model: driver first, then external source, then pull-up, else low.
  always_comb
    for (int i = 0; i < 8; i++)
      pad_di[i] = pad_oe[i] ? pad_do[i] : (ext_en[i] ? ext_val[i] : pad_pu[i]);

  // Behavioural reference state
  logic [7:0] m_lat, m_dir, m_s1, m_s2, m_prev;
  logic       m_puoff;
  logic [3:0] m_rise, m_flg;

  function automatic bit takeover();
    return (mux_cfg == 1'b0) && (op_mode != 2'd0);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_lat <= 8'h00; m_dir <= 8'hFF; m_puoff <= 1'b1; m_rise <= 4'hF; m_flg <= 4'h0;
      m_s1 <= '0; m_s2 <= '0; m_prev <= '0;
    end else begin
      logic [3:0] nf;
      for (int i = 0; i < 4; i++) begin
        bit ev, clr;
        ev = m_rise[i] ? (m_s2[i] && !m_prev[i]) : (!m_s2[i] && m_prev[i]);
        if (i == 3 && takeover()) ev = 0;
        clr = bus_wr && bus_addr == 3'd4 && bus_wdata[i];
        nf[i] = ev || (m_flg[i] && !clr);
      end
      m_flg <= nf;
      if (bus_wr) begin
        case (bus_addr)
          3'd0, 3'd1: m_lat <= bus_wdata;
          3'd2:       m_dir <= bus_wdata;
          3'd3:       begin m_puoff <= bus_wdata[0]; m_rise <= bus_wdata[7:4]; end
          default: ;
        endcase
      end
      m_prev <= m_s2; m_s2 <= m_s1; m_s1 <= pad_di;
    end
  end

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h at %0t", tag, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the reference, away from the active edge.
  always @(negedge clk) begin
    if (rst_n && cmp_on && !done) begin
      logic [7:0] e_oe, e_do, e_pu, e_rd;
      e_oe = ~m_dir; e_do = m_lat;
      if (takeover()) begin e_oe[3] = per_oe; e_do[3] = per_out; end
      e_pu = m_dir & {8{~m_puoff}};
      case (bus_addr)
        3'd0: e_rd = m_s2;
        3'd1: e_rd = m_lat;
        3'd2: e_rd = m_dir;
        3'd3: e_rd = {m_rise, 3'b000, m_puoff};
        3'd4: e_rd = {4'h0, m_flg};
        default: e_rd = 8'h00;
      endcase
      chk("R2 direction/enable", pad_oe & 8'hF7, e_oe & 8'hF7);
      chk("R6 pin3 enable", {7'd0, pad_oe[3]}, {7'd0, e_oe[3]});
      chk("R1 drive value", pad_do & 8'hF7, e_do & 8'hF7);
      chk("R6 pin3 drive", {7'd0, pad_do[3]}, {7'd0, e_do[3]});
      chk("R4 pull-up", pad_pu, e_pu);
      chk("R7 capture", {7'd0, per_cap}, {7'd0, takeover() & m_s2[3]});
      chk("R8 flags", {4'd0, irq_flags}, {4'd0, m_flg});
      case (bus_addr)
        3'd0: chk("R3 live read", bus_rdata, e_rd);
        3'd1: chk("R1 latch read", bus_rdata, e_rd);
        3'd2: chk("R2 dir read", bus_rdata, e_rd);
        3'd3: chk("R5 ctrl read", bus_rdata, e_rd);
        3'd4: chk("R9 flag read", bus_rdata, e_rd);
        default: chk("R10 unmapped read", bus_rdata, e_rd);
      endcase
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    cyc(1);
    bus_wr = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    cyc(4);
    rst_n = 1'b1;
    cmp_on = 1'b1;
    // R5 reset state
    bus_addr = 3'd3; #1 chk("R5 reset ctrl", bus_rdata, 8'hF1);
    bus_addr = 3'd2; #1 chk("R2 reset dir", bus_rdata, 8'hFF);
    bus_addr = 3'd1; #1 chk("R1 reset latch", bus_rdata, 8'h00);
    bus_addr = 3'd4; #1 chk("R9 reset flags", bus_rdata, 8'h00);
    cyc(1);
    // R1 write through live-level address
    wr(3'd0, 8'hA5);
    bus_addr = 3'd1; #1 chk("R1 latch via pin addr", bus_rdata, 8'hA5);
    wr(3'd1, 8'h5A);
    // R2 upper pins outputs, R3 loopback after two flops
    wr(3'd2, 8'h0F);
    bus_addr = 3'd0;
    cyc(1); #0 chk("R3 one edge old", bus_rdata, 8'h00);
    cyc(1); #0 chk("R3 loopback", bus_rdata, 8'h50);
    // R4 pull-ups on inputs create rising edges, R8 flags
    wr(3'd3, 8'hF0);
    cyc(4);
    chk("R8 pull-up edges", {4'd0, irq_flags}, 8'h0F);
    wr(3'd4, 8'h05);
    chk("R9 partial clear", {4'd0, irq_flags}, 8'h0A);
    wr(3'd4, 8'h0F);
    // falling polarity with external drive
    wr(3'd3, 8'h00);
    ext_en = 8'h0F; ext_val = 8'h0F; cyc(4);
    wr(3'd4, 8'h0F);
    ext_val = 8'h00; cyc(4);
    chk("R8 falling edges", {4'd0, irq_flags}, 8'h0F);
    wr(3'd4, 8'h0F);
    // R10 unmapped writes
    wr(3'd6, 8'hFF);
    bus_addr = 3'd1; #1 chk("R10 latch untouched", bus_rdata, 8'h5A);
    // R6/R7 takeover
    ext_en = 8'h00;
    mux_cfg = 1'b0; op_mode = 2'd2; per_oe = 1'b1; per_out = 1'b1;
    #1 chk("R6 takeover enable", {7'd0, pad_oe[3]}, 8'h01);
    cyc(3);
    chk("R7 capture sees pin", {7'd0, per_cap}, 8'h01);
    op_mode = 2'd0;
    #1 chk("R6 internal mode no takeover", {7'd0, pad_oe[3]}, 8'h00);
    // mixed random traffic
    for (int k = 0; k < 4000; k++) begin
      bus_wr    = ($urandom % 4) == 0;
      bus_addr  = 3'($urandom);
      bus_wdata = 8'($urandom);
      if (($urandom % 8) == 0) begin ext_en = 8'($urandom); ext_val = 8'($urandom); end
      if (($urandom % 16) == 0) begin mux_cfg = 1'($urandom); op_mode = 2'($urandom); end
      per_oe = 1'($urandom); per_out = 1'($urandom);
      cyc(1);
    end
    bus_wr = 1'b0;
    cyc(2);
    finish_run();
  end
endmodule